// File: doc/BRIEF.md
# Second-Operand Shifter and Rotated-Immediate Former

This block builds the second ALU operand for a 32-bit RISC datapath. Each cycle it may take one instruction word together with the values already read for the instruction's Rm and Rs register fields and the current carry flag. It returns the operand the ALU should consume, the shifter carry-out for flag update, and a 4-bit condition code taken from the first-source register field. A conditional-move unit uses that code because the first-source field names no register for move instructions.

Three operand forms are recognised from the top three bits of the instruction. The first is a register shifted by a 5-bit constant. The second is a register shifted by an amount held in another register. The third is a 9-bit constant rotated left by a 5-bit count. Any other class yields a zero operand. Results leave through a single registered stage with a valid/ready pair. A result is held unchanged while the consumer stalls, and a new instruction is accepted in the same cycle the held result is taken. With `REG_OUT` set to 0 the stage is bypassed and the handshake passes straight through.

Top module: `sog_operand_gen`

## Requirements
- R1: Class `001` (bits 31:29) yields the 9-bit field in bits 8:0, zero-extended and rotated left by bits 13:9. For a non-zero count the carry-out equals bit 0 of the result.
- R2: Class `001` with a rotate count of 0 yields the zero-extended 9-bit field unchanged, and the carry-out equals the carry input.
- R3: Class `000` with bit 5 clear shifts Rm by the count in bits 13:9. Bits 7:6 select the shift: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The carry-out is the last bit moved out.
- R4: A shift amount of zero, whatever its source, yields Rm unchanged, and the carry-out equals the carry input.
- R5: Class `000` with bit 5 set takes the shift amount from bits 7:0 of the Rs value. Higher Rs bits have no effect.
- R6: A logical shift by exactly 32 yields 0. The carry-out is Rm bit 0 for a left shift and Rm bit 31 for a right shift. A logical shift by more than 32 yields 0 with a carry-out of 0.
- R7: An arithmetic right shift by 32 or more fills every bit with Rm bit 31, and the carry-out is Rm bit 31.
- R8: A rotate right by a non-zero multiple of 32 yields Rm unchanged with carry-out Rm bit 31. Any other non-zero amount rotates by the amount modulo 32.
- R9: Every result carries a condition output equal to instruction bits 22:19, the low four bits of the first-source field in bits 23:19.
- R10: Any class other than `000` and `001` yields operand 0, and the carry-out equals the carry input.
- R11: An instruction is accepted when `in_valid` and `in_ready` are both high at a clock edge, and its result is presented with `out_valid` from the next cycle. `in_ready` is high when no result is pending or the pending one is being taken. A pending result and its outputs hold steady while `out_ready` is low.
- R12: While reset is asserted, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and register values are offered |
| in_ready | output | 1 | Block can accept an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_rm | input | DATA_W | Value read for the Rm field |
| in_rs | input | DATA_W | Value read for the Rs field |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_operand | output | DATA_W | Second ALU operand |
| out_carry | output | 1 | Shifter carry-out |
| out_cond | output | 4 | Condition code from the first-source field |

## Verification
The bench builds the block with its defaults: `DATA_W` 32, an 8-bit register-held shift amount, and the registered output stage on. The 8-bit amount lets amounts of 0 through 255 be driven, which covers the exact-32 boundary, the amounts just above it, rotate amounts that are multiples of 32, and Rs values whose upper bits must be ignored. The registered stage, driven with a pseudo-random ready pattern, exercises both stalled hold and back-to-back acceptance.

// File: rtl/sog_pkg.sv
package sog_pkg;

  localparam int INSTR_W = 32;

  // instruction class and field positions the decoder relies on
  localparam int CLS_HI   = 31;
  localparam int CLS_LO   = 29;
  localparam int COND_HI  = 22;
  localparam int COND_LO  = 19;
  localparam int AMT_HI   = 13;
  localparam int AMT_LO   = 9;
  localparam int KIND_HI  = 7;
  localparam int KIND_LO  = 6;
  localparam int RSEL_BIT = 5;
  localparam int IMM_HI   = 8;
  localparam int IMM_LO   = 0;

  localparam logic [2:0] CLS_REG = 3'b000;
  localparam logic [2:0] CLS_IMM = 3'b001;

  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    FORM_NONE    = 2'd0,
    FORM_REG_IMM = 2'd1,
    FORM_REG_REG = 2'd2,
    FORM_ROT_IMM = 2'd3
  } form_e;

endpackage

// File: rtl/sog_field_decode.sv
module sog_field_decode
  import sog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int IMM_W  = 9,
  parameter int ROT_W  = 5,
  parameter int COND_W = 4
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rs_val,
  output form_e              form,
  output shift_kind_e        kind,
  output logic [AMT_W-1:0]   amt,
  output logic [IMM_W-1:0]   imm,
  output logic [ROT_W-1:0]   rot,
  output logic [COND_W-1:0]  cond
);

  localparam int FIELD_W = AMT_HI - AMT_LO + 1;

  logic [2:0]         cls;
  logic [FIELD_W-1:0] amt_field;
  logic               reg_amt;

  assign cls       = instr[CLS_HI:CLS_LO];
  assign amt_field = instr[AMT_HI:AMT_LO];
  assign reg_amt   = instr[RSEL_BIT];

  always_comb begin
    form = FORM_NONE;
    if (cls == CLS_REG) begin
      form = reg_amt ? FORM_REG_REG : FORM_REG_IMM;
    end else if (cls == CLS_IMM) begin
      form = FORM_ROT_IMM;
    end
  end

  assign kind = shift_kind_e'(instr[KIND_HI:KIND_LO]);
  assign amt  = reg_amt ? rs_val[AMT_W-1:0] : AMT_W'(amt_field);
  assign imm  = instr[IMM_HI:IMM_LO];
  assign rot  = amt_field[ROT_W-1:0];
  assign cond = instr[COND_HI:COND_LO];

  logic unused_bits;
  assign unused_bits = ^{instr[28:23], instr[18:14], rs_val[DATA_W-1:AMT_W]};

endmodule

// File: rtl/sog_barrel.sv
module sog_barrel
  import sog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] x,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] y,
  output logic              cout
);

  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] LIM = AMT_W'(DATA_W);

  logic [AMT_W-1:0]    amt_log;
  logic [AMT_W-1:0]    amt_ari;
  logic [LOG_W-1:0]    amt_rot;
  logic [2*DATA_W-1:0] left_t;
  logic [2*DATA_W-1:0] right_t;
  logic [2*DATA_W-1:0] ari_t;
  logic [2*DATA_W-1:0] rot_t;

  always_comb begin
    // past the width a logical shift is all zero, so clamp one beyond it
    amt_log = (amt > LIM) ? LIM + AMT_W'(1) : amt;
    amt_ari = (amt > LIM) ? LIM : amt;
    amt_rot = amt[LOG_W-1:0];

    left_t  = {{DATA_W{1'b0}}, x} << amt_log;
    right_t = {x, {DATA_W{1'b0}}} >> amt_log;
    ari_t   = $signed({x, {DATA_W{1'b0}}}) >>> amt_ari;
    rot_t   = {x, x} >> amt_rot;

    case (kind)
      SHK_LSL: begin y = left_t[DATA_W-1:0];         cout = left_t[DATA_W];    end
      SHK_LSR: begin y = right_t[2*DATA_W-1:DATA_W]; cout = right_t[DATA_W-1]; end
      SHK_ASR: begin y = ari_t[2*DATA_W-1:DATA_W];   cout = ari_t[DATA_W-1];   end
      default: begin y = rot_t[DATA_W-1:0];          cout = rot_t[DATA_W-1];   end
    endcase

    if (amt == '0) begin
      y    = x;
      cout = cin;
    end
  end

endmodule

// File: rtl/sog_rot_imm.sv
module sog_rot_imm #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 9,
  parameter int ROT_W  = 5
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              cin,
  output logic [DATA_W-1:0] y,
  output logic              cout
);

  logic [DATA_W-1:0] stage [ROT_W+1];

  assign stage[0] = DATA_W'(imm);

  // one fixed left rotation per count bit
  for (genvar i = 0; i < ROT_W; i++) begin : g_step
    localparam int S = 1 << i;
    assign stage[i+1] = rot[i]
      ? {stage[i][DATA_W-1-S:0], stage[i][DATA_W-1 -: S]}
      : stage[i];
  end

  assign y    = stage[ROT_W];
  assign cout = (rot == '0) ? cin : stage[ROT_W][0];

endmodule

// File: rtl/sog_operand_gen.sv
module sog_operand_gen
  import sog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [DATA_W-1:0]  in_rm,
  input  logic [DATA_W-1:0]  in_rs,
  input  logic               in_carry,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_operand,
  output logic               out_carry,
  output logic [3:0]         out_cond
);

  localparam int IMM_W  = IMM_HI - IMM_LO + 1;
  localparam int ROT_W  = AMT_HI - AMT_LO + 1;
  localparam int COND_W = COND_HI - COND_LO + 1;

  form_e             form;
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic [IMM_W-1:0]  imm;
  logic [ROT_W-1:0]  rot;
  logic [COND_W-1:0] cond;

  logic [DATA_W-1:0] bar_y, rimm_y, res_y;
  logic              bar_c, rimm_c, res_c;

  sog_field_decode #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .COND_W(COND_W)
  ) u_dec (
    .instr (in_instr),
    .rs_val(in_rs),
    .form  (form),
    .kind  (kind),
    .amt   (amt),
    .imm   (imm),
    .rot   (rot),
    .cond  (cond)
  );

  sog_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bar (
    .x   (in_rm),
    .kind(kind),
    .amt (amt),
    .cin (in_carry),
    .y   (bar_y),
    .cout(bar_c)
  );

  sog_rot_imm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rimm (
    .imm (imm),
    .rot (rot),
    .cin (in_carry),
    .y   (rimm_y),
    .cout(rimm_c)
  );

  always_comb begin
    case (form)
      FORM_REG_IMM, FORM_REG_REG: begin res_y = bar_y;  res_c = bar_c;    end
      FORM_ROT_IMM:               begin res_y = rimm_y; res_c = rimm_c;   end
      default:                    begin res_y = '0;     res_c = in_carry; end
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] opnd_q;
    logic              carry_q;
    logic [3:0]        cond_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q   <= 1'b0;
        opnd_q  <= '0;
        carry_q <= 1'b0;
        cond_q  <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          opnd_q  <= res_y;
          carry_q <= res_c;
          cond_q  <= cond;
        end
      end
    end

    assign out_valid   = vld_q;
    assign out_operand = opnd_q;
    assign out_carry   = carry_q;
    assign out_cond    = cond_q;
  end else begin : g_flow
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_operand = res_y;
    assign out_carry   = res_c;
    assign out_cond    = cond;
  end

endmodule

// File: rtl/sog_operand_gen_checker.sv
module sog_operand_gen_checker #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_instr,
  input logic [DATA_W-1:0] in_rm,
  input logic [DATA_W-1:0] in_rs,
  input logic              in_carry,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_operand,
  input logic              out_carry,
  input logic [3:0]        out_cond
);

  logic       acc;
  logic [2:0] cls;
  assign acc = in_valid && in_ready;
  assign cls = in_instr[31:29];

  logic unused_rs;
  assign unused_rs = ^in_rs[DATA_W-1:8];

  if (REG_OUT) begin : g_chk
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid); // R11

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_operand)
                                     && $stable(out_carry) && $stable(out_cond))); // R11

    AST_COND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (out_cond == $past(in_instr[22:19]))); // R9

    AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cls == 3'b000 && !in_instr[5] && in_instr[13:9] == 5'd0)
      |=> (out_operand == $past(in_rm) && out_carry == $past(in_carry))); // R4

    AST_IMM_NOROT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cls == 3'b001 && in_instr[13:9] == 5'd0)
      |=> (out_operand == {{(DATA_W-9){1'b0}}, $past(in_instr[8:0])}
           && out_carry == $past(in_carry))); // R2

    AST_LSL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cls == 3'b000 && in_instr[5] && in_instr[7:6] == 2'b00 && in_rs[7:0] == 8'd32)
      |=> (out_operand == '0 && out_carry == $past(in_rm[0]))); // R6

    AST_OTHER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cls != 3'b000 && cls != 3'b001)
      |=> (out_operand == '0 && out_carry == $past(in_carry))); // R10
  end

endmodule

bind sog_operand_gen sog_operand_gen_checker #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_instr   (in_instr),
  .in_rm      (in_rm),
  .in_rs      (in_rs),
  .in_carry   (in_carry),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_operand(out_operand),
  .out_carry  (out_carry),
  .out_cond   (out_cond)
);

// File: tb/sog_operand_gen_bench.sv
`timescale 1ns/1ps
module sog_operand_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rm = '0;
  logic [31:0] in_rs = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_operand;
  logic        out_carry;
  logic [3:0]  out_cond;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [15:0] bp_lfsr = 16'hACE1;
  logic [31:0] rnd = 32'h1234_5678;

  logic [36:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  sog_operand_gen u_sog_operand_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rm(in_rm), .in_rs(in_rs), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_operand(out_operand),
    .out_carry(out_carry), .out_cond(out_cond)
  );

  // reference: one bit at a time, carry is whatever left last
  function automatic logic [32:0] ref_shift(input logic [31:0] x, input logic [1:0] sh,
                                            input int n, input logic cin);
    logic [31:0] r = x;
    logic c = cin;
    for (int i = 0; i < n; i++) begin
      case (sh)
        2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  function automatic logic [36:0] model(input logic [31:0] ins, input logic [31:0] rm,
                                        input logic [31:0] rs, input logic cin);
    logic [32:0] cr;
    logic [31:0] r;
    logic c;
    if (ins[31:29] == 3'b000) begin
      cr = ref_shift(rm, ins[7:6], ins[5] ? int'(rs[7:0]) : int'(ins[13:9]), cin);
    end else if (ins[31:29] == 3'b001) begin
      r = {23'd0, ins[8:0]};
      c = cin;
      for (int i = 0; i < int'(ins[13:9]); i++) begin
        c = r[31];
        r = {r[30:0], r[31]};
      end
      cr = {c, r};
    end else begin
      cr = {cin, 32'd0};
    end
    return {ins[22:19], cr};
  endfunction

  function automatic logic [31:0] i_sh(input logic [1:0] sh, input logic [4:0] amt,
                                       input logic by_reg, input logic [3:0] cond);
    return {3'b000, 5'b01101, 1'b0, cond, 5'd7, amt, 1'b0, sh, by_reg, 5'd3};
  endfunction

  function automatic logic [31:0] i_imm(input logic [4:0] rot, input logic [8:0] imm,
                                        input logic [3:0] cond);
    return {3'b001, 5'b01101, 1'b0, cond, 5'd2, rot, imm};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [31:0] rm, input logic [31:0] rs,
                      input logic cin, input string tag);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_rm = rm; in_rs = rs; in_carry = cin;
    do begin
      #9;
      ok = in_ready;
      if (!ok) @(negedge clk);
    end while (!ok);
    @(posedge clk);
    exp_q.push_back(model(ins, rm, rs, cin));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: decides ready, then compares what will transfer on the next edge
  always @(negedge clk) begin
    if (mon_on) begin
      bp_lfsr   = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      out_ready = bp_lfsr[0] | bp_lfsr[3];
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11 unexpected result got %h expected none", out_operand);
        end else begin
          logic [36:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (out_operand !== e[31:0]) begin
            errors++;
            $display("FAIL %s operand got %h expected %h", t, out_operand, e[31:0]);
          end
          checks++;
          if (out_carry !== e[32]) begin
            errors++;
            $display("FAIL %s carry got %b expected %b", t, out_carry, e[32]);
          end
          checks++;
          if (out_cond !== e[36:33]) begin
            errors++;
            $display("FAIL R9 cond got %h expected %h", out_cond, e[36:33]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 valid/ready got %b%b expected 01", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n  = 1'b1;
    mon_on = 1'b1;

    // R4 zero amounts, immediate and register forms
    for (int k = 0; k < 4; k++) send(i_sh(2'(k), 5'd0, 1'b0, 4'(k)), 32'h8000_0001, 0, 1'b1, "R4");
    send(i_sh(2'd3, 5'd0, 1'b1, 4'h5), 32'hDEAD_BEEF, 32'h0000_0100, 1'b0, "R4");
    // R3 constant-amount shifts
    send(i_sh(2'd0, 5'd4,  1'b0, 4'h1), 32'hF000_000F, 0, 1'b0, "R3");
    send(i_sh(2'd1, 5'd1,  1'b0, 4'h2), 32'h0000_0003, 0, 1'b0, "R3");
    send(i_sh(2'd2, 5'd31, 1'b0, 4'h3), 32'hC000_0000, 0, 1'b0, "R3");
    send(i_sh(2'd3, 5'd8,  1'b0, 4'h4), 32'h1234_5680, 0, 1'b0, "R3");
    // R5 upper Rs bits ignored
    send(i_sh(2'd1, 5'd9, 1'b1, 4'h6), 32'hFFFF_FFF0, 32'hFFFF_FF04, 1'b0, "R5");
    // R6 logical boundaries
    send(i_sh(2'd0, 5'd9, 1'b1, 4'h7), 32'h0000_0001, 32'd32, 1'b0, "R6");
    send(i_sh(2'd1, 5'd9, 1'b1, 4'h8), 32'h8000_0000, 32'd32, 1'b0, "R6");
    send(i_sh(2'd0, 5'd9, 1'b1, 4'h9), 32'hFFFF_FFFF, 32'd33, 1'b1, "R6");
    send(i_sh(2'd1, 5'd9, 1'b1, 4'hA), 32'hFFFF_FFFF, 32'd200, 1'b1, "R6");
    // R7 arithmetic saturation
    send(i_sh(2'd2, 5'd9, 1'b1, 4'hB), 32'h8000_1234, 32'd40, 1'b0, "R7");
    send(i_sh(2'd2, 5'd9, 1'b1, 4'hC), 32'h7FFF_FFFF, 32'd255, 1'b1, "R7");
    // R8 rotate multiples and modulo
    send(i_sh(2'd3, 5'd9, 1'b1, 4'hD), 32'h8000_0002, 32'd32, 1'b0, "R8");
    send(i_sh(2'd3, 5'd9, 1'b1, 4'hE), 32'h0000_0002, 32'd64, 1'b1, "R8");
    send(i_sh(2'd3, 5'd9, 1'b1, 4'hF), 32'h0000_0010, 32'd36, 1'b0, "R8");
    // R1 and R2 rotated immediates
    send(i_imm(5'd31, 9'h1FF, 4'h1), 0, 0, 1'b0, "R1");
    send(i_imm(5'd5,  9'h101, 4'h2), 0, 0, 1'b0, "R1");
    send(i_imm(5'd24, 9'h0FF, 4'h3), 0, 0, 1'b0, "R1");
    send(i_imm(5'd0,  9'h1A5, 4'h4), 0, 0, 1'b1, "R2");
    // R10 other classes
    send({3'b010, i_sh(2'd0, 5'd3, 1'b0, 4'h9)[28:0]}, 32'hFFFF_FFFF, 0, 1'b1, "R10");
    send({3'b111, i_sh(2'd1, 5'd3, 1'b0, 4'h6)[28:0]}, 32'hFFFF_FFFF, 0, 1'b0, "R10");
    idle();
    repeat (3) @(negedge clk);

    // mixed traffic under back-pressure (R11)
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ins, rm, rs;
      string t;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      ins = rnd;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      rm = rnd;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      rs = rnd;
      if (k % 4 != 3) ins[31:29] = 3'(k % 2);
      if (ins[31:29] == 3'b000) t = ins[5] ? "R5" : "R3";
      else if (ins[31:29] == 3'b001) t = "R1";
      else t = "R10";
      send(ins, rm, rs, rs[31], t);
      if (k % 7 == 0) idle();
    end
    idle();

    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending results got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule